// File: doc/BRIEF.md
# Triggered Multi-Mode Sample Buffer

This block sits between a three-axis sensor front end and a register readout path. Each incoming sample carries three 16-bit two's-complement axis values. It is held in a 32-entry store with a registered output stage in front of it, so up to 33 samples can wait for readout. A control write picks one of four behaviours:
- **Pass-through:** nothing is buffered and the output shows the newest sample.
- **Fill-and-stop:** samples are kept until the buffer is full, and later ones are dropped.
- **Circular stream:** the oldest sample is replaced, so the buffer always holds the most recent samples.
- **Trigger capture:** a programmable number of pre-event samples is kept. After the trigger event the buffer fills to full and then stops.

The readout side always sees the oldest held sample on `out_data`. A one-cycle read strobe removes it, and the next sample appears after the same clock edge. Status outputs give the live sample count, a trigger-occurred flag and a watermark flag. The trigger flag is also routed to one of two interrupt lines. Every status output is registered and moves on the same edge as the count.

Top module: `trig_sample_fifo`

## Requirements
- R1: After a synchronous reset the block is in pass-through mode with the threshold field at 31 and trigger select 0. `entries` is 0. `stat_trig`, `stat_wm`, `irq1` and `irq2` are all 0, and `out_data` is all zeros.
- R2: A cycle with `cfg_we` high loads the mode, threshold and trigger-select fields. The mode encoding is: 0 pass-through, 1 fill-and-stop, 2 circular stream, 3 trigger capture. On the next edge `entries` is 0 and `stat_trig` is 0. A sample, read strobe or trigger in that cycle is ignored.
- R3: `entries` never exceeds 33, which is the 32 stored samples plus the output stage.
- R4: In fill-and-stop mode a sample is accepted only if `entries` is below 33 or a read removes one entry in the same cycle. Any other sample is dropped, and `out_data` is left unchanged.
- R5: In circular-stream mode a sample that arrives when the count is 33 and no read is made discards the oldest sample. The count stays at 33, and the buffer then holds the latest 33 samples.
- R6: In trigger-capture mode before the trigger, with threshold N, the buffer keeps the latest N samples. A sample beyond N discards the oldest one. With N equal to 0 every pre-trigger sample is discarded.
- R7: In trigger-capture mode after the trigger, samples are accepted until the count reaches 33. Later samples are dropped.
- R8: `stat_wm` is 1 exactly when the threshold field is 0, or when the mode is not pass-through and `entries` is at least the threshold. It changes on the same edge as `entries`.
- R9: `trig_in` high in trigger-capture mode sets `stat_trig` on the next edge, and the flag stays set until the next control write. In other modes `trig_in` has no effect. `irq1` is `stat_trig` when trigger select is 0, `irq2` is `stat_trig` when it is 1, and the other line stays 0.
- R10: `out_data` presents the oldest held sample. X is in bits 15:0, Y in 31:16 and Z in 47:32, with the low byte of each axis at the lower address. A read strobe with `entries` above 0 removes exactly one sample, and the next one is shown after that edge.
- R11: An accepted sample and a read in the same cycle both take effect, and `entries` is unchanged.
- R12: A read strobe while `entries` is 0 leaves `entries` at 0 and `out_data` unchanged.
- R13: In pass-through mode `entries` stays 0 and `out_data` takes each new sample on the next edge. The read strobe and `trig_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_mode | input | 2 | Mode field (0 pass, 1 fill, 2 stream, 3 trigger) |
| cfg_trig_sel | input | 1 | Trigger routing: 0 to irq1, 1 to irq2 |
| cfg_samples | input | 5 | Watermark threshold / pre-trigger sample count |
| smp_valid | input | 1 | New sample present this cycle |
| smp_x | input | 16 | X axis value |
| smp_y | input | 16 | Y axis value |
| smp_z | input | 16 | Z axis value |
| trig_in | input | 1 | Trigger event |
| rd_stb | input | 1 | Read strobe, removes the presented sample |
| out_data | output | 48 | Oldest held sample {Z, Y, X} |
| entries | output | 6 | Number of samples held (0..33) |
| stat_trig | output | 1 | Trigger has occurred |
| stat_wm | output | 1 | Watermark reached |
| irq1 | output | 1 | Trigger interrupt, select 0 |
| irq2 | output | 1 | Trigger interrupt, select 1 |

## Verification
The point of contention is a cycle that both writes and reads. An arriving sample can meet a read strobe, or meet an internal discard of the oldest entry in stream and pre-trigger capture. The bench provokes this deliberately at a full buffer in fill mode, at full in stream mode, and with exactly one sample held, where the new sample must go straight to the output stage. It also sprays random mixes of samples, reads and triggers across every mode. A behavioural queue model predicts the count, the presented sample and every flag after each edge, and any divergence is reported in the cycle it appears.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_FILL   = 2'd1,
    MODE_STREAM = 2'd2,
    MODE_TRIG   = 2'd3
  } mode_e;
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW  = $clog2(DEPTH),
  localparam int CAP = DEPTH + 1,
  localparam int CW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_trig_sel,
  input  logic [AW-1:0] cfg_samples,
  input  logic          smp_valid,
  input  logic          trig_in,
  input  logic          rd_stb,
  input  logic [CW-1:0] cnt,
  output logic          push,
  output logic          pop,
  output mode_e         mode_q,
  output logic          trig_q,
  output mode_e         mode_nxt,
  output logic [AW-1:0] nsamp_nxt,
  output logic          sel_nxt,
  output logic          trig_nxt
);
  logic [AW-1:0] nsamp_q;
  logic          sel_q;
  logic          rd_pop, pre_trig, overwrite, drop;
  logic [CW-1:0] limit;

  // admission decision for the incoming sample
  always_comb begin
    rd_pop    = rd_stb && !cfg_we && (mode_q != MODE_BYPASS) && (cnt != '0);
    pre_trig  = (mode_q == MODE_TRIG) && !trig_q;
    limit     = pre_trig ? CW'(nsamp_q) : CW'(CAP);
    overwrite = (mode_q == MODE_STREAM) || pre_trig;
    push      = 1'b0;
    drop      = 1'b0;
    if (!cfg_we && smp_valid && (mode_q != MODE_BYPASS)) begin
      if ((cnt < limit) || rd_pop) begin
        push = 1'b1;
      end else if (overwrite && (cnt != '0)) begin
        push = 1'b1;
        drop = 1'b1;
      end
    end
    pop = rd_pop || drop;
  end

  always_comb begin
    mode_nxt  = cfg_we ? mode_e'(cfg_mode) : mode_q;
    nsamp_nxt = cfg_we ? cfg_samples : nsamp_q;
    sel_nxt   = cfg_we ? cfg_trig_sel : sel_q;
    trig_nxt  = cfg_we ? 1'b0 : (trig_q || ((mode_q == MODE_TRIG) && trig_in));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_BYPASS;
      nsamp_q <= '1;
      sel_q   <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      nsamp_q <= nsamp_nxt;
      sel_q   <= sel_nxt;
      trig_q  <= trig_nxt;
    end
  end
endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH = 32,
  parameter int SW    = 48,
  localparam int AW  = $clog2(DEPTH),
  localparam int CAP = DEPTH + 1,
  localparam int CW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic          thru,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [SW-1:0] mem_rd;
  logic          ram_we;

  assign mem_rd = mem[rd_ptr];
  // a sample bypasses the array when the output stage is (or becomes) empty
  assign ram_we = push && !flush && (cnt != '0) && !(pop && (cnt == CW'(1)));

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      head   <= '0;
    end else if (flush) begin
      cnt    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (thru) head <= din;
      if (pop) begin
        if (cnt > CW'(1)) begin
          head   <= mem_rd;
          rd_ptr <= rd_ptr + AW'(1);
        end else if (push) begin
          head <= din;
        end
      end else if (push && (cnt == '0)) begin
        head <= din;
      end
      if (ram_we) wr_ptr <= wr_ptr + AW'(1);
    end
  end
endmodule

// File: rtl/tsf_status.sv
module tsf_status
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW  = $clog2(DEPTH),
  localparam int CAP = DEPTH + 1,
  localparam int CW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode_nxt,
  input  logic [AW-1:0] nsamp_nxt,
  input  logic          sel_nxt,
  input  logic          trig_nxt,
  input  logic [CW-1:0] cnt_nxt,
  output logic          wm,
  output logic          irq1,
  output logic          irq2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wm   <= 1'b0;
      irq1 <= 1'b0;
      irq2 <= 1'b0;
    end else begin
      wm   <= (nsamp_nxt == '0) ||
              ((mode_nxt != MODE_BYPASS) && (cnt_nxt >= CW'(nsamp_nxt)));
      irq1 <= trig_nxt && !sel_nxt;
      irq2 <= trig_nxt && sel_nxt;
    end
  end
endmodule

// File: rtl/trig_sample_fifo.sv
module trig_sample_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int AXES  = 3,
  localparam int AW  = $clog2(DEPTH),
  localparam int CAP = DEPTH + 1,
  localparam int CW  = $clog2(CAP + 1),
  localparam int SW  = DW * AXES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_trig_sel,
  input  logic [AW-1:0] cfg_samples,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_x,
  input  logic [DW-1:0] smp_y,
  input  logic [DW-1:0] smp_z,
  input  logic          trig_in,
  input  logic          rd_stb,
  output logic [SW-1:0] out_data,
  output logic [CW-1:0] entries,
  output logic          stat_trig,
  output logic          stat_wm,
  output logic          irq1,
  output logic          irq2
);
  logic [DW-1:0] axis_in [AXES];
  logic [SW-1:0] din;
  logic          push, pop, load_thru, trig_q, sel_nxt, trig_nxt;
  mode_e         mode_q, mode_nxt;
  logic [AW-1:0] nsamp_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  assign axis_in[0] = smp_x;
  assign axis_in[1] = smp_y;
  if (AXES > 2) begin : g_z
    assign axis_in[2] = smp_z;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_pack
    assign din[a*DW +: DW] = axis_in[a];
  end

  assign load_thru = smp_valid && !cfg_we && (mode_q == MODE_BYPASS);

  tsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_trig_sel(cfg_trig_sel), .cfg_samples(cfg_samples),
    .smp_valid(smp_valid), .trig_in(trig_in), .rd_stb(rd_stb), .cnt(cnt),
    .push(push), .pop(pop), .mode_q(mode_q), .trig_q(trig_q),
    .mode_nxt(mode_nxt), .nsamp_nxt(nsamp_nxt), .sel_nxt(sel_nxt),
    .trig_nxt(trig_nxt)
  );

  tsf_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
    .clk(clk), .rst(rst), .flush(cfg_we), .push(push), .pop(pop),
    .thru(load_thru), .din(din), .head(out_data), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  tsf_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst), .mode_nxt(mode_nxt), .nsamp_nxt(nsamp_nxt),
    .sel_nxt(sel_nxt), .trig_nxt(trig_nxt), .cnt_nxt(cnt_nxt),
    .wm(stat_wm), .irq1(irq1), .irq2(irq2)
  );

  assign entries   = cnt;
  assign stat_trig = trig_q;
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int CAP = 33,
  parameter int CW  = 6,
  parameter int AW  = 5,
  parameter int SW  = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_samples,
  input logic          smp_valid,
  input logic          rd_stb,
  input logic          trig_in,
  input logic [1:0]    mode,
  input logic [CW-1:0] entries,
  input logic          stat_trig,
  input logic          stat_wm,
  input logic          irq1,
  input logic          irq2,
  input logic [SW-1:0] out_data
);
  p_cap_r3: assert property (@(posedge clk) disable iff (rst)
    entries <= CW'(CAP));

  p_flush_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (entries == '0) && !stat_trig);

  p_wm_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_samples == '0) |=> stat_wm);

  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && entries == CW'(CAP) && !rd_stb && !cfg_we)
    |=> (entries == CW'(CAP)) && $stable(out_data));

  p_pair_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && smp_valid && rd_stb && !cfg_we &&
     entries != '0 && entries < CW'(CAP))
    |=> entries == $past(entries));

  p_empty_rd_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !smp_valid && !cfg_we && entries == '0)
    |=> (entries == '0) && $stable(out_data));

  p_trig_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_trig) |-> ($past(trig_in) && $past(mode) == 2'd3 && !$past(cfg_we)));

  p_irq_route_r9: assert property (@(posedge clk) disable iff (rst)
    !(irq1 && irq2) && ((irq1 || irq2) == stat_trig));

  p_bypass_r13: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> entries == '0);
endmodule

bind trig_sample_fifo tsf_checker #(.CAP(CAP), .CW(CW), .AW(AW), .SW(SW)) u_tsf_checker (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_samples(cfg_samples),
  .smp_valid(smp_valid), .rd_stb(rd_stb), .trig_in(trig_in), .mode(mode_q),
  .entries(entries), .stat_trig(stat_trig), .stat_wm(stat_wm),
  .irq1(irq1), .irq2(irq2), .out_data(out_data)
);

// File: tb/trig_sample_fifo_bench.sv
module trig_sample_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_trig_sel = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [4:0]  cfg_samples = 5'd0;
  logic        smp_valid = 1'b0, trig_in = 1'b0, rd_stb = 1'b0;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [47:0] out_data;
  logic [5:0]  entries;
  logic        stat_trig, stat_wm, irq1, irq2;

  trig_sample_fifo u_trig_sample_fifo (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_trig_sel(cfg_trig_sel), .cfg_samples(cfg_samples),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .trig_in(trig_in), .rd_stb(rd_stb), .out_data(out_data),
    .entries(entries), .stat_trig(stat_trig), .stat_wm(stat_wm),
    .irq1(irq1), .irq2(irq2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [47:0] mq[$];
  int          m_mode = 0, m_ns = 31;
  bit          m_sel = 0, m_trg = 0, m_wm = 0;
  logic [47:0] m_out = '0;
  int          checks = 0, fails = 0, seqn = 1;
  string       phase = "R1";

  function automatic logic [47:0] smp(int k);
    return {16'(k) ^ 16'h5A5A, 16'(k * 7), 16'(k)};
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int sz, lim;
    bit rdpop, pre, push, drop;
    if (rst) begin
      mq.delete(); m_mode = 0; m_ns = 31; m_sel = 0; m_trg = 0; m_out = '0;
    end else if (cfg_we) begin
      mq.delete(); m_mode = cfg_mode; m_ns = cfg_samples; m_sel = cfg_trig_sel; m_trg = 0;
    end else if (m_mode == 0) begin
      if (smp_valid) m_out = {smp_z, smp_y, smp_x};
    end else begin
      sz = mq.size();
      rdpop = rd_stb && sz > 0;
      pre = (m_mode == 3) && !m_trg;
      lim = pre ? m_ns : CAP;
      push = 0; drop = 0;
      if (smp_valid) begin
        if (sz < lim || rdpop) push = 1;
        else if ((m_mode == 2 || pre) && sz > 0) begin push = 1; drop = 1; end
      end
      if (rdpop) void'(mq.pop_front());
      if (drop) void'(mq.pop_front());
      if (push) mq.push_back({smp_z, smp_y, smp_x});
      if (mq.size() > 0) m_out = mq[0];
      if (m_mode == 3 && trig_in) m_trg = 1;
    end
    m_wm = (m_ns == 0) || (m_mode != 0 && mq.size() >= m_ns);
  endtask

  task automatic compare_all();
    check(phase, "entries", 64'(entries), 64'(mq.size()));
    check(phase, "out_data", 64'(out_data), 64'(m_out));
    check(phase, "stat_wm", 64'(stat_wm), 64'(m_wm));
    check(phase, "stat_trig", 64'(stat_trig), 64'(m_trg));
    check(phase, "irq1", 64'(irq1), 64'(m_trg && !m_sel));
    check(phase, "irq2", 64'(irq2), 64'(m_trg && m_sel));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    smp_valid = 0; rd_stb = 0; trig_in = 0; cfg_we = 0;
  endtask

  task automatic give_sample();
    smp_valid = 1;
    {smp_z, smp_y, smp_x} = smp(seqn);
    seqn++;
  endtask

  task automatic write_cfg(int mode, bit sel, int ns);
    cfg_we = 1; cfg_mode = 2'(mode); cfg_trig_sel = sel; cfg_samples = 5'(ns);
    tick();
  endtask

  task automatic pushn(int n);
    for (int i = 0; i < n; i++) begin give_sample(); tick(); end
  endtask

  task automatic rand_run(int n, int pv, int pr, int pt);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(99) < pv) give_sample();
      rd_stb  = ($urandom_range(99) < pr);
      trig_in = ($urandom_range(99) < pt);
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s0;
    phase = "R1";
    rst = 1;
    repeat (3) tick();
    rst = 0;
    check("R1", "reset entries", 64'(entries), 0);
    check("R1", "reset out", 64'(out_data), 0);
    check("R1", "reset flags", 64'({stat_trig, stat_wm, irq1, irq2}), 0);

    // fill-and-stop
    phase = "R4";
    write_cfg(1, 0, 8);
    check("R2", "entries after cfg", 64'(entries), 0);
    s0 = seqn;
    pushn(40);
    check("R4", "fill count", 64'(entries), CAP);
    check("R4", "fill head", 64'(out_data), 64'(smp(s0)));
    check("R8", "wm at full", 64'(stat_wm), 1);
    phase = "R11";
    for (int i = 0; i < 4; i++) begin give_sample(); rd_stb = 1; tick(); end
    check("R11", "count kept at full", 64'(entries), CAP);
    check("R10", "head after 4 reads", 64'(out_data), 64'(smp(s0 + 4)));
    phase = "R12";
    for (int i = 0; i < 36; i++) begin rd_stb = 1; tick(); end
    check("R12", "empty count", 64'(entries), 0);
    s0 = seqn;
    give_sample(); tick();
    give_sample(); rd_stb = 1; tick();
    check("R11", "single entry pair", 64'(out_data), 64'(smp(s0 + 1)));
    check("R11", "single entry count", 64'(entries), 1);

    // circular stream
    phase = "R5";
    write_cfg(2, 0, 20);
    s0 = seqn;
    pushn(40);
    check("R5", "stream count", 64'(entries), CAP);
    check("R5", "stream oldest", 64'(out_data), 64'(smp(s0 + 7)));
    rand_run(200, 60, 35, 0);

    // trigger capture
    phase = "R6";
    write_cfg(3, 1, 4);
    s0 = seqn;
    pushn(10);
    check("R6", "pre count", 64'(entries), 4);
    check("R6", "pre oldest", 64'(out_data), 64'(smp(s0 + 6)));
    phase = "R9";
    trig_in = 1; tick();
    check("R9", "trig flag", 64'(stat_trig), 1);
    check("R9", "irq routing", 64'({irq1, irq2}), 64'(2'b01));
    phase = "R7";
    pushn(40);
    check("R7", "post full count", 64'(entries), CAP);
    check("R7", "post head", 64'(out_data), 64'(smp(s0 + 6)));
    rand_run(150, 50, 30, 5);
    phase = "R6";
    write_cfg(3, 0, 0);
    pushn(5);
    check("R6", "N=0 discards", 64'(entries), 0);
    trig_in = 1; tick();
    check("R9", "irq1 routing", 64'({irq1, irq2}), 64'(2'b10));

    // pass-through
    phase = "R13";
    write_cfg(0, 0, 0);
    check("R8", "wm zero threshold", 64'(stat_wm), 1);
    s0 = seqn;
    give_sample(); rd_stb = 1; trig_in = 1; tick();
    check("R13", "thru out", 64'(out_data), 64'(smp(s0)));
    check("R13", "thru count", 64'(entries), 0);
    check("R13", "thru trig ignored", 64'(stat_trig), 0);
    write_cfg(0, 0, 9);
    rand_run(40, 50, 50, 50);

    // mixed modes
    phase = "R3";
    for (int k = 0; k < 8; k++) begin
      write_cfg($urandom_range(3), 1'($urandom_range(1)), $urandom_range(31));
      rand_run(120, 65, 30, 4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule